// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block watches over running software by counting ticks of a slow 32768 Hz enable. Software must restart the count by writing a clear word before 0.75 seconds (24576 ticks) elapse. If the period runs out, the block raises a reset request for one clock cycle. Distributing that reset to the rest of the system is outside the block.

A clear write is accepted only if its two low bits carry the key value binary 01. The upper bits of the word play no part. A write with any other value in the low bits is treated as a software fault, so it raises a reset request at once instead of being dropped.

During standby the count goes on only while the slow oscillator is running. If the oscillator is off, no ticks are counted and the count stays where it was. A static strap input can switch the whole function off.

Top module: `wdog_keyed`

## Requirements
- R1: While and after reset, `rst_req` is low and the count is zero, so a full period of 24576 effective ticks is needed before any timeout.
- R2: A write with `wr_data[1:0]` equal to 2'b01 restarts the count from zero and raises no request. Bits `wr_data[15:2]` have no effect.
- R3: A write with `wr_data[1:0]` equal to 2'b00, 2'b10 or 2'b11 makes `rst_req` high in the cycle after the write. The count also restarts from zero.
- R4: When the 24576th effective tick since the last restart is sampled, `rst_req` is high in the next cycle and the count restarts from zero.
- R5: Each cause produces a request exactly one cycle wide. `rst_req` returns low on the following cycle unless a new cause arrives.
- R6: While `standby` is high and `slow_osc_on` is low, `tick_en` is ignored and the count holds its value.
- R7: While `standby` is high and `slow_osc_on` is high, ticks are counted as in normal operation.
- R8: While `wdog_en` is low, `rst_req` stays low whatever the other inputs do, and the count is held at zero.
- R9: A valid clear sampled in the same cycle as the terminal tick wins over the timeout. No request follows, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdog_en | input | 1 | Static strap; low removes the watchdog function |
| tick_en | input | 1 | One-cycle enable at the 32768 Hz rate |
| standby | input | 1 | High while the system is in standby |
| slow_osc_on | input | 1 | High while the 32768 Hz oscillator runs |
| wr_stb | input | 1 | Write strobe for the clear register |
| wr_data | input | 16 | Write data; bits [1:0] carry the clear key |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench places a clear exactly on the terminal tick. A design that let the timeout win there would issue a spurious reset. It writes bad keys and valid keys with random upper bits. If the decode ignored bad keys, a fault would go unreported. If it looked at the upper bits, some good clears would be refused. A long standby stretch with the oscillator off, followed by one with it on, shows whether a count that froze or leaked moves the timeout by the wrong number of cycles. Toggling the strap checks that the count does not survive a disabled spell and fire early once the strap is raised again.

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int TIMEOUT_TICKS = 24576,
  parameter int DATA_W        = 16,
  parameter logic [1:0] KEY   = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdog_en,
  input  logic              tick_en,
  input  logic              standby,
  input  logic              slow_osc_on,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rst_req
);
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

  logic [CNT_W-1:0] cnt;

  wire tick_ok  = tick_en && (!standby || slow_osc_on);
  wire key_good = wr_stb && (wr_data[1:0] == KEY);
  wire key_bad  = wr_stb && (wr_data[1:0] != KEY);
  wire expire   = tick_ok && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      rst_req <= 1'b0;
    end else if (!wdog_en) begin
      cnt     <= '0;
      rst_req <= 1'b0;
    end else if (key_bad) begin
      cnt     <= '0;
      rst_req <= 1'b1;
    end else if (key_good) begin
      cnt     <= '0;
      rst_req <= 1'b0;
    end else if (expire) begin
      cnt     <= '0;
      rst_req <= 1'b1;
    end else begin
      rst_req <= 1'b0;
      if (tick_ok) cnt <= cnt + 1'b1;
    end
  end

  // R8
  strap_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wdog_en |=> !rst_req);
  // R3
  bad_key_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_en && wr_stb && wr_data[1:0] != KEY) |=> rst_req);
  // R2
  good_key_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_en && wr_stb && wr_data[1:0] == KEY) |=> (!rst_req && cnt == '0));
  // R6
  standby_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_en && standby && !slow_osc_on && !wr_stb) |=> $stable(cnt));
  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R5
  req_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cnt == '0);
endmodule

// File: tb/tb_wdog_keyed.sv
module tb_wdog_keyed;
  localparam int T = 24576;

  logic clk = 0, rst_n = 0, wdog_en = 1, tick_en = 0, standby = 0, slow_osc_on = 1, wr_stb = 0;
  logic [15:0] wr_data = '0;
  logic rst_req;

  int compared = 0, mismatched = 0, mcnt = 0, cycles = 0, pulses = 0;
  logic mreq = 0;
  string cur = "R1";

  always #5 clk = ~clk;

  wdog_keyed dut (.clk(clk), .rst_n(rst_n), .wdog_en(wdog_en), .tick_en(tick_en),
    .standby(standby), .slow_osc_on(slow_osc_on), .wr_stb(wr_stb), .wr_data(wr_data),
    .rst_req(rst_req));

  always @(posedge clk) begin
    cycles++;
    if (!rst_n || !wdog_en) begin mcnt = 0; mreq = 0; end
    else if (wr_stb && wr_data[1:0] != 2'b01) begin mreq = 1; mcnt = 0; end
    else if (wr_stb) begin mreq = 0; mcnt = 0; end
    else if (tick_en && (!standby || slow_osc_on) && mcnt == T-1) begin mreq = 1; mcnt = 0; end
    else begin mreq = 0; if (tick_en && (!standby || slow_osc_on)) mcnt++; end
  end

  always @(negedge clk) begin
    compared++;
    if (rst_req !== mreq) begin
      mismatched++;
      $display("FAIL %s cycle %0d: rst_req=%b expected %b", cur, cycles, rst_req, mreq);
    end
    if (rst_req) pulses++;
  end

  task automatic check(input string r, input logic exp);
    compared++;
    if (rst_req !== exp) begin
      mismatched++;
      $display("FAIL %s: rst_req=%b expected %b", r, rst_req, exp);
    end
  endtask

  task automatic run(input int n, input logic tk);
    for (int i = 0; i < n; i++) begin tick_en = tk; @(negedge clk); end
    tick_en = 0;
  endtask

  task automatic wr(input logic [15:0] d, input logic tk);
    wr_stb = 1; wr_data = d; tick_en = tk; @(negedge clk);
    wr_stb = 0; tick_en = 0;
  endtask

  initial begin
    #200000000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1; @(negedge clk);
    cur = "R4"; run(T - 1, 1); check("R4", 1'b0);
    run(1, 1); check("R4", 1'b1);
    @(negedge clk); check("R5", 1'b0);
    cur = "R9"; run(T - 1, 1);
    wr(16'hA5F1, 1); check("R9", 1'b0);
    run(5, 1);
    cur = "R3"; wr(16'h0002, 0); check("R3", 1'b1);
    @(negedge clk); check("R5", 1'b0);
    wr(16'hFFFF, 1); check("R3", 1'b1);
    wr(16'h1230, 0); check("R3", 1'b1);
    cur = "R2";
    for (int k = 0; k < 3; k++) begin
      run(T - 100, 1); wr({$urandom()} [15:0] & 16'hFFFC | 16'h0001, 1); check("R2", 1'b0);
    end
    cur = "R6"; run(100, 1);
    standby = 1; slow_osc_on = 0; run(3000, 1); check("R6", 1'b0);
    cur = "R7"; slow_osc_on = 1; run(T - 101, 1); check("R7", 1'b0);
    run(1, 1); check("R7", 1'b1);
    standby = 0;
    cur = "R8"; run(500, 1); wdog_en = 0; run(3000, 1);
    wr(16'h0003, 0); check("R8", 1'b0);
    wdog_en = 1; run(T - 1, 1); check("R8", 1'b0);
    run(1, 1); check("R4", 1'b1);
    run(10, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule